// File: doc/BRIEF.md
# Tiled background pixel generator

The block turns a raster position into one background pixel. Each clock it takes a horizontal and a vertical dot count. It works out whether that dot lies on the visible screen. It then locates the tile under the dot, fetches the tile-map word and the two-bitplane character row from video memory, and forms a 2-bit colour index. The index is looked up in palette memory, and the 15-bit colour is widened to 24-bit RGB with an opaque alpha byte. Alongside the pixel it gives the byte address at which the pixel belongs in a 512-pixel-wide, four-bytes-per-pixel framebuffer.

The memories sit outside the block. There are two read ports into video memory, one for the tile map and one for character data, plus one palette read port. Each returns its data one clock after the address is sampled. The pipeline accepts a new dot every clock and emits a result five clocks later. The configuration inputs must be held steady while a frame is drawn: the map base, character base, map width in tiles, and the two tile-size selects.

The dot classifier has three named regions. ACTIVE covers the visible window. HBLANK covers a visible line outside the horizontal window. VBLANK covers any line outside the vertical window and has priority over HBLANK. There are no stored states and no transitions between them: each dot is classified afresh.

Top module: `bg_tile_pixel`

## Requirements
- R1: `pix_valid` is high exactly five clocks after a dot with `hcount` in 22..277 and `vcount` in 1..224, both inclusive, and is low five clocks after any other dot.
- R2: For a valid pixel, `fb_addr` equals ((hcount-22) + (vcount-1)*512)*4, taken from the dot five clocks earlier.
- R3: The tile-map read address is `map_base` + (x / tw) + (y / th) * `map_cols`, where x = hcount-22 and y = vcount-1. The tile width tw is 16 when `tile_w16`=1 and 8 otherwise. The tile height th is selected the same way by `tile_h16`.
- R4: Bits 9:0 of the tile-map word form the character index; bits 15:10 are ignored. The character row address is `chr_base` + index*tw + (y mod th).
- R5: In the character word, bits 7:0 are bitplane 0 and bits 15:8 are bitplane 1. Let c = x mod 8; for 16-wide tiles the column also wraps every 8 pixels. The pixel at column c takes bit 7-c of each plane. Plane 1 gives colour-index bit 1 and plane 0 gives bit 0.
- R6: The palette read address is the colour index plus a palette base of zero, wrapping at 8 bits. In the palette entry, bits 4:0 are red, bits 9:5 are green and bits 14:10 are blue.
- R7: Each 5-bit component v is widened to 8 bits as {v, v[4:2]}. So 5'h1F becomes 8'hFF and 5'b10101 becomes 8'hAD.
- R8: `pix_rgba` carries red in bits 7:0, green in 15:8, blue in 23:16, and 8'hFF in 31:24.
- R9: While `rst_n` is low, and on the first clocks after it rises, `pix_valid` is low.
- R10: Consecutive visible dots each yield their own pixel on consecutive clocks, across whole lines and frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hcount | input | 9 | Horizontal dot count, 0..339 |
| vcount | input | 9 | Vertical line count |
| map_base | input | 16 | Tile-map base word address |
| chr_base | input | 16 | Character data base word address |
| map_cols | input | 7 | Background width in tiles |
| tile_w16 | input | 1 | 1: tiles 16 wide, 0: 8 wide |
| tile_h16 | input | 1 | 1: tiles 16 high, 0: 8 high |
| map_addr | output | 16 | Tile-map read address |
| map_rdata | input | 16 | Tile-map word, one clock after the address |
| chr_addr | output | 16 | Character row read address |
| chr_rdata | input | 16 | Character row word, one clock after the address |
| pal_addr | output | 8 | Palette read address |
| pal_rdata | input | 16 | Palette entry, one clock after the address |
| pix_valid | output | 1 | Pixel and address below are for a visible dot |
| pix_rgba | output | 32 | Widened colour, R/G/B/A byte lanes |
| fb_addr | output | 19 | Framebuffer byte address of the pixel |

## Verification
Three things happen in the same clock while dots stream through the block. A finished pixel leaves the output, a tile-map fetch starts for a dot four places later, and a character fetch is in flight for the dot between them. Across a line edge, a visible pixel also leaves while blanking dots are still being classified. The bench drives one dot per clock through whole frames and across the first and last visible columns and lines. Each output is checked against a model that recomputes address, colour and validity for the dot issued five clocks earlier.

// File: rtl/bgp_pkg.sv
package bgp_pkg;

    typedef enum logic [1:0] {
        RG_ACTIVE = 2'd0,
        RG_HBLANK = 2'd1,
        RG_VBLANK = 2'd2
    } region_e;

endpackage

// File: rtl/bgp_locator.sv
module bgp_locator
    import bgp_pkg::*;
#(
    parameter int HC_W     = 9,
    parameter int VC_W     = 9,
    parameter int ADDR_W   = 16,
    parameter int COLS_W   = 7,
    parameter int FB_AW    = 19,
    parameter int H_FIRST  = 22,
    parameter int H_LAST   = 277,
    parameter int V_FIRST  = 1,
    parameter int V_LAST   = 224,
    parameter int LINE_PIX = 512
) (
    input  logic [HC_W-1:0]   hcount,
    input  logic [VC_W-1:0]   vcount,
    input  logic [ADDR_W-1:0] map_base,
    input  logic [COLS_W-1:0] map_cols,
    input  logic              tile_w16,
    input  logic              tile_h16,
    output logic              active,
    output logic [2:0]        col,
    output logic [3:0]        row,
    output logic [ADDR_W-1:0] map_addr,
    output logic [FB_AW-1:0]  fb
);
    localparam int LINE_SHIFT = $clog2(LINE_PIX);

    region_e         region;
    logic [HC_W-1:0] x;
    logic [VC_W-1:0] y;
    logic [HC_W-1:0] tcol;
    logic [VC_W-1:0] trow;

    always_comb begin
        if (vcount < VC_W'(V_FIRST) || vcount > VC_W'(V_LAST))
            region = RG_VBLANK;
        else if (hcount < HC_W'(H_FIRST) || hcount > HC_W'(H_LAST))
            region = RG_HBLANK;
        else
            region = RG_ACTIVE;
    end

    always_comb begin
        x        = hcount - HC_W'(H_FIRST);
        y        = vcount - VC_W'(V_FIRST);
        tcol     = tile_w16 ? (x >> 4) : (x >> 3);
        trow     = tile_h16 ? (y >> 4) : (y >> 3);
        col      = x[2:0];
        row      = tile_h16 ? y[3:0] : {1'b0, y[2:0]};
        map_addr = map_base + ADDR_W'(tcol) + ADDR_W'(trow) * ADDR_W'(map_cols);
        fb       = FB_AW'((FB_AW'(x) + (FB_AW'(y) << LINE_SHIFT)) << 2);
        unique case (region)
            RG_ACTIVE: active = 1'b1;
            RG_HBLANK: active = 1'b0;
            RG_VBLANK: active = 1'b0;
            default:   active = 1'b0;
        endcase
    end
endmodule

// File: rtl/bgp_plane_pick.sv
module bgp_plane_pick #(
    parameter int PLANE_BITS = 8
) (
    input  logic [2*PLANE_BITS-1:0]         word,
    input  logic [$clog2(PLANE_BITS)-1:0]   col,
    output logic [1:0]                      idx
);
    logic [1:0] cand [PLANE_BITS];

    for (genvar c = 0; c < PLANE_BITS; c++) begin : g_col
        assign cand[c] = {word[2*PLANE_BITS-1-c], word[PLANE_BITS-1-c]};
    end

    assign idx = cand[col];
endmodule

// File: rtl/bgp_rgb_widen.sv
module bgp_rgb_widen #(
    parameter int COMP_IN  = 5,
    parameter int COMP_OUT = 8,
    parameter int NCOMP    = 3
) (
    input  logic [NCOMP*COMP_IN-1:0]  narrow,
    output logic [NCOMP*COMP_OUT-1:0] wide
);
    localparam int FILL = COMP_OUT - COMP_IN;

    for (genvar k = 0; k < NCOMP; k++) begin : g_comp
        assign wide[k*COMP_OUT +: COMP_OUT] =
            {narrow[k*COMP_IN +: COMP_IN], narrow[k*COMP_IN + COMP_IN - FILL +: FILL]};
    end
endmodule

// File: rtl/bg_tile_pixel.sv
module bg_tile_pixel
    import bgp_pkg::*;
#(
    parameter int HC_W      = 9,
    parameter int VC_W      = 9,
    parameter int ADDR_W    = 16,
    parameter int COLS_W    = 7,
    parameter int PAL_AW    = 8,
    parameter int FB_AW     = 19,
    parameter int CHR_IDX_W = 10,
    parameter int PAL_BASE  = 0,
    parameter int H_FIRST   = 22,
    parameter int H_LAST    = 277,
    parameter int V_FIRST   = 1,
    parameter int V_LAST    = 224,
    parameter int LINE_PIX  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HC_W-1:0]   hcount,
    input  logic [VC_W-1:0]   vcount,
    input  logic [ADDR_W-1:0] map_base,
    input  logic [ADDR_W-1:0] chr_base,
    input  logic [COLS_W-1:0] map_cols,
    input  logic              tile_w16,
    input  logic              tile_h16,
    output logic [ADDR_W-1:0] map_addr,
    input  logic [15:0]       map_rdata,
    output logic [ADDR_W-1:0] chr_addr,
    input  logic [15:0]       chr_rdata,
    output logic [PAL_AW-1:0] pal_addr,
    input  logic [15:0]       pal_rdata,
    output logic              pix_valid,
    output logic [31:0]       pix_rgba,
    output logic [FB_AW-1:0]  fb_addr
);
    logic              loc_active;
    logic [2:0]        loc_col;
    logic [3:0]        loc_row;
    logic [ADDR_W-1:0] loc_map;
    logic [FB_AW-1:0]  loc_fb;

    logic              s1_v, s2_v, s3_v, s4_v;
    logic [2:0]        s1_col, s2_col, s3_col;
    logic [3:0]        s1_row, s2_row;
    logic              s1_tw, s2_tw;
    logic [FB_AW-1:0]  s1_fb, s2_fb, s3_fb, s4_fb;

    logic [CHR_IDX_W-1:0] chr_idx;
    logic [1:0]           pix_idx;
    logic [23:0]          rgb_wide;
    logic                 unused_bits;

    bgp_locator #(
        .HC_W(HC_W), .VC_W(VC_W), .ADDR_W(ADDR_W), .COLS_W(COLS_W), .FB_AW(FB_AW),
        .H_FIRST(H_FIRST), .H_LAST(H_LAST), .V_FIRST(V_FIRST), .V_LAST(V_LAST),
        .LINE_PIX(LINE_PIX)
    ) u_loc (
        .hcount(hcount), .vcount(vcount), .map_base(map_base), .map_cols(map_cols),
        .tile_w16(tile_w16), .tile_h16(tile_h16),
        .active(loc_active), .col(loc_col), .row(loc_row),
        .map_addr(loc_map), .fb(loc_fb)
    );

    // stage 1: dot classified, tile-map address presented to memory
    // stage 2: map word back, character row address formed
    // stage 3: character word back, palette address formed
    // stage 4: palette entry back, widened into the output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v <= 1'b0; s2_v <= 1'b0; s3_v <= 1'b0; s4_v <= 1'b0;
            s1_col <= '0; s2_col <= '0; s3_col <= '0;
            s1_row <= '0; s2_row <= '0;
            s1_tw <= 1'b0; s2_tw <= 1'b0;
            s1_fb <= '0; s2_fb <= '0; s3_fb <= '0; s4_fb <= '0;
            map_addr <= '0;
        end else begin
            s1_v <= loc_active; s1_col <= loc_col; s1_row <= loc_row;
            s1_tw <= tile_w16;  s1_fb <= loc_fb;   map_addr <= loc_map;
            s2_v <= s1_v; s2_col <= s1_col; s2_row <= s1_row; s2_tw <= s1_tw; s2_fb <= s1_fb;
            s3_v <= s2_v; s3_col <= s2_col; s3_fb <= s2_fb;
            s4_v <= s3_v; s4_fb <= s3_fb;
        end
    end

    assign chr_idx  = map_rdata[CHR_IDX_W-1:0];
    assign chr_addr = chr_base
                    + (s2_tw ? ADDR_W'({chr_idx, 4'b0000}) : ADDR_W'({chr_idx, 3'b000}))
                    + ADDR_W'(s2_row);

    bgp_plane_pick #(.PLANE_BITS(8)) u_pick (
        .word(chr_rdata), .col(s3_col), .idx(pix_idx)
    );

    assign pal_addr = PAL_AW'(PAL_BASE) + PAL_AW'(pix_idx);

    bgp_rgb_widen #(.COMP_IN(5), .COMP_OUT(8), .NCOMP(3)) u_widen (
        .narrow(pal_rdata[14:0]), .wide(rgb_wide)
    );

    assign unused_bits = ^{map_rdata[15:CHR_IDX_W], pal_rdata[15]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_rgba  <= '0;
            fb_addr   <= '0;
        end else begin
            pix_valid <= s4_v;
            if (s4_v) begin
                pix_rgba <= {8'hFF, rgb_wide};
                fb_addr  <= s4_fb;
            end
        end
    end
endmodule

// File: rtl/bg_tile_pixel_chk.sv
module bg_tile_pixel_chk #(
    parameter int HC_W    = 9,
    parameter int VC_W    = 9,
    parameter int FB_AW   = 19,
    parameter int H_FIRST = 22,
    parameter int H_LAST  = 277,
    parameter int V_FIRST = 1,
    parameter int V_LAST  = 224
) (
    input logic             clk,
    input logic             rst_n,
    input logic [HC_W-1:0]  hcount,
    input logic [VC_W-1:0]  vcount,
    input logic [15:0]      pal_rdata,
    input logic             pix_valid,
    input logic [31:0]      pix_rgba,
    input logic [FB_AW-1:0] fb_addr
);
    logic [2:0] cyc;
    logic       vis;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cyc <= '0;
        else if (cyc != 3'd7) cyc <= cyc + 3'd1;
    end

    assign vis = (hcount >= HC_W'(H_FIRST)) && (hcount <= HC_W'(H_LAST)) &&
                 (vcount >= VC_W'(V_FIRST)) && (vcount <= VC_W'(V_LAST));

    // R1: a valid pixel only ever follows a visible dot
    a_r1_valid_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 3'd5 && pix_valid) |-> $past(vis, 5));

    // R1: every visible dot yields a valid pixel
    a_r1_active_emits: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 3'd5 && $past(vis, 5)) |-> pix_valid);

    // R2: framebuffer byte address of the emitted pixel
    a_r2_fb_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 3'd5 && pix_valid) |->
        fb_addr == FB_AW'(((FB_AW'($past(hcount, 5)) - FB_AW'(H_FIRST)) +
                           (FB_AW'($past(vcount, 5)) - FB_AW'(V_FIRST)) * FB_AW'(512)) * FB_AW'(4)));

    // R7: red widened from the palette entry returned one clock earlier
    a_r7_red_widen: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 3'd1 && pix_valid) |->
        pix_rgba[7:0] == {$past(pal_rdata[4:0]), $past(pal_rdata[4:2])});

    // R9: nothing valid right after reset
    a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc < 3'd5) |-> !pix_valid);
endmodule

bind bg_tile_pixel bg_tile_pixel_chk #(
    .HC_W(HC_W), .VC_W(VC_W), .FB_AW(FB_AW),
    .H_FIRST(H_FIRST), .H_LAST(H_LAST), .V_FIRST(V_FIRST), .V_LAST(V_LAST)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
    .pal_rdata(pal_rdata), .pix_valid(pix_valid), .pix_rgba(pix_rgba), .fb_addr(fb_addr)
);

// File: tb/bg_tile_pixel_bench.sv
module bg_tile_pixel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NTAB = 11;
    localparam int TAB_H   [NTAB] = '{22, 78, 21, 278, 277, 23, 22, 22, 100, 339, 277};
    localparam int TAB_V   [NTAB] = '{1, 1, 1, 1, 1, 2, 0, 224, 225, 100, 224};
    localparam int TAB_VAL [NTAB] = '{1, 1, 0, 0, 1, 1, 0, 1, 0, 0, 1};
    localparam int TAB_FB  [NTAB] = '{0, 224, 0, 0, 1020, 2052, 0, 456704, 0, 0, 457724};
    localparam logic [31:0] TAB_RGBA [NTAB] = '{32'hFFDE52AD, 32'hFFFFFFFF, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    localparam int MAP_BASE = 'h100;
    localparam int CHR_BASE = 0;
    localparam int COLS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  hcount = '0, vcount = '0;
    logic        tile_w16 = 1'b0, tile_h16 = 1'b0;
    logic [15:0] map_addr, chr_addr, map_rdata, chr_rdata, pal_rdata;
    logic [7:0]  pal_addr;
    logic        pix_valid;
    logic [31:0] pix_rgba;
    logic [18:0] fb_addr;

    logic [15:0] vram [0:4095];
    logic [15:0] pal  [0:255];

    int tests = 0, fails = 0, range_bad = 0;
    bit checking = 0;
    int hist_h [5], hist_v [5], hist_t [5];
    bit hist_on [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) begin
        map_rdata <= vram[map_addr[11:0]];
        chr_rdata <= vram[chr_addr[11:0]];
        pal_rdata <= pal[pal_addr];
    end

    bg_tile_pixel u_bg_tile_pixel (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
        .map_base(16'(MAP_BASE)), .chr_base(16'(CHR_BASE)), .map_cols(7'(COLS)),
        .tile_w16(tile_w16), .tile_h16(tile_h16),
        .map_addr(map_addr), .map_rdata(map_rdata),
        .chr_addr(chr_addr), .chr_rdata(chr_rdata),
        .pal_addr(pal_addr), .pal_rdata(pal_rdata),
        .pix_valid(pix_valid), .pix_rgba(pix_rgba), .fb_addr(fb_addr)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit visible(input int h, input int v);
        return (h >= 22 && h <= 277 && v >= 1 && v <= 224);
    endfunction

    function automatic logic [7:0] widen(input int c);
        return 8'(((c << 3) | (c >> 2)) & 255);
    endfunction

    // colour model: R3 tile lookup, R4 char row, R5 planes, R6 palette, R7/R8 packing
    function automatic logic [31:0] model_rgba(input int h, input int v);
        int x = h - 22, y = v - 1;
        int tw = tile_w16 ? 16 : 8, th = tile_h16 ? 16 : 8;
        int mw, ci, cw, c, ix, pe;
        mw = vram[(MAP_BASE + x / tw + (y / th) * COLS) % 4096];
        ci = mw & 1023;
        cw = vram[(CHR_BASE + ci * tw + y % th) % 4096];
        c  = x % 8;
        ix = (((cw >> (15 - c)) & 1) << 1) | ((cw >> (7 - c)) & 1);
        pe = pal[ix % 256];
        return {8'hFF, widen((pe >> 10) & 31), widen((pe >> 5) & 31), widen(pe & 31)};
    endfunction

    task automatic compare(input int h, input int v, input int t);
        bit ev;
        int efb;
        logic [31:0] erg;
        ev  = (t >= 0) ? (TAB_VAL[t] != 0) : visible(h, v);
        efb = (t >= 0) ? TAB_FB[t] : ((h - 22) + (v - 1) * 512) * 4;
        check(pix_valid == ev, (t >= 0) ? "R1 window edge" : "R1 R10 stream", 32'(pix_valid), 32'(ev));
        if (ev) begin
            check(fb_addr == 19'(efb), "R2 fb_addr", 32'(fb_addr), 32'(efb));
            erg = (t >= 0 && TAB_RGBA[t] != 0) ? TAB_RGBA[t] : model_rgba(h, v);
            check(pix_rgba == erg, (t >= 0) ? "R7 R8 widened colour" : "R3 R4 R5 R6 pixel colour",
                  pix_rgba, erg);
        end
    endtask

    task automatic dot(input int h, input int v, input int t);
        @(negedge clk);
        if (hist_on[4]) compare(hist_h[4], hist_v[4], hist_t[4]);
        if (checking && (chr_addr > 16'd4095 || map_addr > 16'd4095)) range_bad++;
        for (int i = 4; i > 0; i--) begin
            hist_h[i] = hist_h[i-1]; hist_v[i] = hist_v[i-1];
            hist_t[i] = hist_t[i-1]; hist_on[i] = hist_on[i-1];
        end
        hist_h[0] = h; hist_v[0] = v; hist_t[0] = t; hist_on[0] = 1'b1;
        hcount = 9'(h); vcount = 9'(v);
    endtask

    task automatic drain();
        for (int i = 0; i < 6; i++) dot(0, 0, -1);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int a = 0; a < 4096; a++) vram[a] = '0;
        for (int a = 0; a < 256; a++) vram[a] = 16'((a * 16'h9E37) ^ 16'h5A5A);
        for (int r = 8; r < 16; r++) vram[r] = 16'h00FF;   // char 1: index 1 everywhere
        for (int r = 16; r < 24; r++) vram[r] = 16'hFFFF;  // char 2: index 3 everywhere
        // map words carry junk in bits 15:10 (R4)
        for (int i = 0; i < 1024; i++) vram[MAP_BASE + i] = 16'hFC00 | 16'((i * 7 + 1) % 16);
        for (int p = 0; p < 256; p++) pal[p] = 16'h1234;
        pal[0] = 16'h0000; pal[1] = 16'h6D55; pal[2] = 16'h03E0; pal[3] = 16'h7FFF;
        for (int i = 0; i < 5; i++) hist_on[i] = 1'b0;

        // R9: reset state
        repeat (3) @(negedge clk);
        check(pix_valid == 1'b0, "R9 valid during reset", 32'(pix_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pix_valid == 1'b0, "R9 valid after reset", 32'(pix_valid), 0);
        checking = 1;

        // table of window edges, addresses and known colours
        for (int t = 0; t < NTAB; t++) dot(TAB_H[t], TAB_V[t], t);
        drain();

        // R10: one full frame streamed with 8x8 tiles
        for (int v = 0; v < 262; v++)
            for (int h = 0; h < 340; h++) dot(h, v, -1);
        drain();

        // R3 R5: 16x16 tiles, column wraps every 8 pixels
        tile_w16 = 1'b1; tile_h16 = 1'b1;
        for (int v = 0; v < 40; v++)
            for (int h = 0; h < 340; h++) dot(h, v, -1);
        drain();

        // R3: mixed 16-wide by 8-high tiles
        tile_h16 = 1'b0;
        for (int v = 0; v < 12; v++)
            for (int h = 0; h < 340; h++) dot(h, v, -1);
        drain();

        check(range_bad == 0, "R4 read address beyond character index bits", 32'(range_bad), 0);

        // R9: reset mid-stream drops valid
        for (int h = 22; h < 30; h++) dot(h, 5, -1);
        rst_n = 1'b0;
        @(negedge clk);
        check(pix_valid == 1'b0, "R9 reset mid-stream", 32'(pix_valid), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule